// File: doc/BRIEF.md
# Lane Drive Adjust Mapper

This block turns a display link sink's requests for per-lane drive changes into legal transmitter settings. Software or a training sequencer presents the packed adjustment requests (one 4-bit field per lane), an optional packed post-cursor2 request, and the number of active lanes, then pulses `start`. The block captures these values and visits the active lanes in ascending order, one lane per accepted beat. For each lane it emits a voltage-swing level, a pre-emphasis level and a post-cursor2 level for the analog driver. It also builds the bytes that go back to the sink: one drive byte per lane and packed post-cursor2 nibbles.

Swing and pre-emphasis are limited together so that their sum never goes above 3. Whenever a limit is hit, a saturation flag is set in the byte returned to the sink. The per-lane drive stream uses valid/ready. `drv_valid` rises in the cycle after an accepted start. While `drv_ready` is low, the current beat holds with all its fields unchanged. A beat is consumed on any clock edge where `drv_valid` and `drv_ready` are both high. No lane is skipped or repeated because of back-pressure. `start`, `busy` and `done` are plain control and status levels.

Top module: `lane_drive_mapper`

## Requirements
- R1: While reset is held, `busy`, `done` and `drv_valid` are low, and `lane_cfg` and `pc2_cfg` are all zeros.
- R2: Lane i takes its request from `adj_req[4i+3:4i]`, which is the low nibble of byte i>>1 for even i and the high nibble for odd i. Lane i takes its post-cursor2 request from `pc2_req[2i+1:2i]`.
- R3: In a request nibble, bits 1:0 are the requested swing and bits 3:2 are the requested pre-emphasis. If pre-emphasis is below 3 and swing is below (3 - pre-emphasis), both pass through unchanged. The lane byte is then pre-emphasis*8 + swing.
- R4: A requested pre-emphasis of 3 gives pre-emphasis 3 and swing 0. The lane byte is then 0x38, where bit 5 is the pre-emphasis-limit flag.
- R5: If pre-emphasis is below 3 and swing is at least (3 - pre-emphasis), swing becomes (3 - pre-emphasis). Bit 2 of the lane byte is set as the swing-limit flag. Output swing + pre-emphasis never exceeds 3.
- R6: A post-cursor2 request of 3 gives level 3 and nibble 0x7, where bit 2 is the limit flag. A lower request passes through unchanged. Lane i's nibble sits at `pc2_cfg[4i+3:4i]`. If `pc2_en` was low at start, every post-cursor2 level and nibble is 0.
- R7: Beats carry lanes 0, 1, ... in order on `drv_lane`, one per accepted beat. While `drv_ready` is low, `drv_valid` stays high and every beat field holds its value.
- R8: `busy` is high from the cycle after an accepted start until the last beat is accepted. `done` rises in the cycle after the last accepted beat, stays high until the next accepted start, and is never high together with `busy`.
- R9: A `start` while `busy` is high is ignored. The requests, enable and lane count are captured only when a start is accepted.
- R10: An accepted start clears `lane_cfg` and `pc2_cfg` to zero. Lane i's byte and nibble are written in the cycle after its beat is accepted. Lanes at or above the lane count stay zero.
- R11: The lane count is normally 1, 2 or 4. A count of 0 is treated as 1, and a count above 4 is treated as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a pass; ignored while busy |
| lane_cnt | input | 3 | Number of active lanes |
| pc2_en | input | 1 | Enable post-cursor2 handling |
| adj_req | input | 16 | Packed per-lane swing/pre-emphasis requests |
| pc2_req | input | 8 | Packed 2-bit post-cursor2 requests |
| drv_ready | input | 1 | Consumer accepts current drive beat |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Pass finished; held until next start |
| drv_valid | output | 1 | Drive beat valid |
| drv_lane | output | 2 | Lane index of current beat |
| drv_swing | output | 2 | Voltage-swing level |
| drv_pre | output | 2 | Pre-emphasis level |
| drv_pc2 | output | 2 | Post-cursor2 level |
| lane_cfg | output | 32 | Per-lane bytes returned to the sink, lane i at bits 8i+7:8i |
| pc2_cfg | output | 16 | Packed post-cursor2 nibbles, lane i at bits 4i+3:4i |

## Verification
A wrong lane index shows up on `drv_lane` and in the beat fields in the same cycle. A bad limit decision shows up on `drv_swing` and `drv_pre` in the same cycle and in `lane_cfg` one cycle later. A result register that was not cleared, or was written to the wrong lane, shows up in `lane_cfg` or `pc2_cfg` in the first cycle after the start or the write. A corrupted lane count or `busy`/`done` state shows up one cycle after the last beat, when the bench's model expects `done`. The bench therefore compares every output against its model on every clock, with extra tests for back-pressure holds and for starts pulsed while busy.

// File: rtl/ldm_pkg.sv
package ldm_pkg;

  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;
  localparam int PC_W   = 2;
  localparam int LVL_W  = 2;

  // Highest legal level for any of the three controls
  localparam logic [LVL_W-1:0] LVL_TOP = 2'd3;

  typedef struct packed {
    logic [LVL_W-1:0]  swing;
    logic [LVL_W-1:0]  pre;
    logic [LVL_W-1:0]  pc2;
    logic [BYTE_W-1:0] cfg;
    logic [NIB_W-1:0]  pc_nib;
  } lane_res_t;

endpackage

// File: rtl/ldm_clamp.sv
module ldm_clamp
  import ldm_pkg::*;
(
  input  logic [NIB_W-1:0] nib,
  input  logic [PC_W-1:0]  pc_field,
  input  logic             pc_on,
  output lane_res_t        res
);

  logic [LVL_W-1:0] vs_req;
  logic [LVL_W-1:0] pe_req;
  logic [LVL_W-1:0] vs_cap;
  logic [LVL_W:0]   vs_out;   // {limit flag, level}
  logic [LVL_W:0]   pe_out;   // {limit flag, level}
  logic [PC_W-1:0]  pc_in;
  logic [PC_W:0]    pc_out;   // {limit flag, level}

  always_comb begin
    vs_req = nib[1:0];
    pe_req = nib[3:2];
    vs_cap = LVL_TOP - pe_req;

    if (pe_req == LVL_TOP) begin
      pe_out = {1'b1, LVL_TOP};
      vs_out = '0;
    end else if (vs_req >= vs_cap) begin
      pe_out = {1'b0, pe_req};
      vs_out = {1'b1, vs_cap};
    end else begin
      pe_out = {1'b0, pe_req};
      vs_out = {1'b0, vs_req};
    end

    pc_in  = pc_on ? pc_field : '0;
    pc_out = (pc_in == LVL_TOP) ? {1'b1, LVL_TOP} : {1'b0, pc_in};

    res.swing  = vs_out[LVL_W-1:0];
    res.pre    = pe_out[LVL_W-1:0];
    res.pc2    = pc_out[PC_W-1:0];
    res.cfg    = {2'b00, pe_out, vs_out};
    res.pc_nib = {1'b0, pc_out};
  end

endmodule

// File: rtl/ldm_walker.sv
module ldm_walker #(
  parameter int LANES = 4,
  parameter int CW    = $clog2(LANES + 1),
  parameter int IW    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] lane_cnt,
  input  logic          ready,
  output logic          busy,
  output logic          done,
  output logic [IW-1:0] idx,
  output logic          load,
  output logic          step,
  output logic [CW-1:0] cnt
);

  logic          busy_q;
  logic          done_q;
  logic [IW-1:0] idx_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_norm;
  logic          last;

  always_comb begin
    if (lane_cnt == '0)
      cnt_norm = CW'(1);
    else if (lane_cnt > CW'(LANES))
      cnt_norm = CW'(LANES);
    else
      cnt_norm = lane_cnt;
  end

  assign load = start & ~busy_q;
  assign step = busy_q & ready;
  assign last = (CW'(idx_q) == (cnt_q - CW'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= CW'(LANES);
    end else if (load) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= cnt_norm;
    end else if (step) begin
      if (last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        idx_q  <= '0;
      end else begin
        idx_q  <= idx_q + 1'b1;
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign idx  = idx_q;
  assign cnt  = cnt_q;

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q)); // R8
  AST_LANE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last) |=> (idx_q == $past(idx_q) + 1'b1)); // R7
  AST_LAST_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last) |=> (done_q && !busy_q)); // R8
  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(cnt_q)); // R9
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (CW'(idx_q) < cnt_q)); // R11

endmodule

// File: rtl/ldm_packer.sv
module ldm_packer
  import ldm_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CW    = $clog2(LANES + 1),
  parameter int IW    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    wr_en,
  input  logic [IW-1:0]           wr_idx,
  input  lane_res_t               res,
  input  logic [CW-1:0]           cnt,
  output logic [LANES*BYTE_W-1:0] lane_cfg,
  output logic [LANES*NIB_W-1:0]  pc2_cfg
);

  logic [LANES-1:0][BYTE_W-1:0] cfg_q;
  logic [LANES-1:0][NIB_W-1:0]  pcn_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        cfg_q[g] <= '0;
        pcn_q[g] <= '0;
      end else if (wr_en && (wr_idx == IW'(g))) begin
        cfg_q[g] <= res.cfg;
        pcn_q[g] <= res.pc_nib;
      end
    end

    assign lane_cfg[g*BYTE_W +: BYTE_W] = cfg_q[g];
    assign pc2_cfg[g*NIB_W +: NIB_W]    = pcn_q[g];

    AST_UNUSED_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (CW'(g) >= cnt) |-> (cfg_q[g] == '0 && pcn_q[g] == '0)); // R10
    AST_PRE_LIMIT_NO_SWING: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[g][5] |-> (cfg_q[g][2:0] == 3'd0 && cfg_q[g][4:3] == 2'd3)); // R4
  end

endmodule

// File: rtl/lane_drive_mapper.sv
module lane_drive_mapper
  import ldm_pkg::*;
#(
  parameter  int LANES = 4,
  localparam int CW    = $clog2(LANES + 1),
  localparam int IW    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [CW-1:0]           lane_cnt,
  input  logic                    pc2_en,
  input  logic [LANES*NIB_W-1:0]  adj_req,
  input  logic [LANES*PC_W-1:0]   pc2_req,
  input  logic                    drv_ready,
  output logic                    busy,
  output logic                    done,
  output logic                    drv_valid,
  output logic [IW-1:0]           drv_lane,
  output logic [LVL_W-1:0]        drv_swing,
  output logic [LVL_W-1:0]        drv_pre,
  output logic [LVL_W-1:0]        drv_pc2,
  output logic [LANES*BYTE_W-1:0] lane_cfg,
  output logic [LANES*NIB_W-1:0]  pc2_cfg
);

  logic [LANES*NIB_W-1:0] req_q;
  logic [LANES*PC_W-1:0]  pcr_q;
  logic                   pen_q;

  logic          load;
  logic          step;
  logic [IW-1:0] idx;
  logic [CW-1:0] cnt;

  logic [NIB_W-1:0] cur_nib;
  logic [PC_W-1:0]  cur_pc;
  lane_res_t        cur_res;

  ldm_walker #(.LANES(LANES), .CW(CW), .IW(IW)) u_walker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .lane_cnt (lane_cnt),
    .ready    (drv_ready),
    .busy     (busy),
    .done     (done),
    .idx      (idx),
    .load     (load),
    .step     (step),
    .cnt      (cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      pcr_q <= '0;
      pen_q <= 1'b0;
    end else if (load) begin
      req_q <= adj_req;
      pcr_q <= pc2_req;
      pen_q <= pc2_en;
    end
  end

  assign cur_nib = req_q[idx*NIB_W +: NIB_W];
  assign cur_pc  = pcr_q[idx*PC_W +: PC_W];

  ldm_clamp u_clamp (
    .nib      (cur_nib),
    .pc_field (cur_pc),
    .pc_on    (pen_q),
    .res      (cur_res)
  );

  ldm_packer #(.LANES(LANES), .CW(CW), .IW(IW)) u_packer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (load),
    .wr_en    (step),
    .wr_idx   (idx),
    .res      (cur_res),
    .cnt      (cnt),
    .lane_cfg (lane_cfg),
    .pc2_cfg  (pc2_cfg)
  );

  assign drv_valid = busy;
  assign drv_lane  = idx;
  assign drv_swing = cur_res.swing;
  assign drv_pre   = cur_res.pre;
  assign drv_pc2   = cur_res.pc2;

  AST_LEVEL_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    drv_valid |-> (({1'b0, drv_swing} + {1'b0, drv_pre}) <= 3'd3)); // R5
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_valid && !drv_ready) |=> (drv_valid && $stable(drv_lane) &&
      $stable(drv_swing) && $stable(drv_pre) && $stable(drv_pc2))); // R7
  AST_PC2_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_valid && !pen_q) |-> (drv_pc2 == '0)); // R6
  AST_REQ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(req_q) && $stable(pcr_q) && $stable(pen_q))); // R9
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (lane_cfg == '0 && pc2_cfg == '0)); // R10

endmodule

// File: tb/tb_lane_drive_mapper.sv
module tb_lane_drive_mapper;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  lane_cnt = '0;
  logic        pc2_en = 1'b0;
  logic [15:0] adj_req = '0;
  logic [7:0]  pc2_req = '0;
  logic        drv_ready = 1'b0;
  logic        busy, done, drv_valid;
  logic [1:0]  drv_lane, drv_swing, drv_pre, drv_pc2;
  logic [31:0] lane_cfg;
  logic [15:0] pc2_cfg;

  lane_drive_mapper dut (
    .clk(clk), .rst_n(rst_n), .start(start), .lane_cnt(lane_cnt),
    .pc2_en(pc2_en), .adj_req(adj_req), .pc2_req(pc2_req),
    .drv_ready(drv_ready), .busy(busy), .done(done), .drv_valid(drv_valid),
    .drv_lane(drv_lane), .drv_swing(drv_swing), .drv_pre(drv_pre),
    .drv_pc2(drv_pc2), .lane_cfg(lane_cfg), .pc2_cfg(pc2_cfg)
  );

  int checks = 0;
  int fails  = 0;
  int wd     = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Behavioural expectation of a lane byte from a request nibble
  function automatic int exp_cfg(input int n);
    int pe, vs;
    pe = n / 4;
    vs = n % 4;
    if (pe == 3) return 32 + 24;
    if (vs >= 3 - pe) return pe * 8 + 4 + (3 - pe);
    return pe * 8 + vs;
  endfunction

  function automatic int exp_pcn(input int f);
    return (f == 3) ? 7 : f;
  endfunction

  // Reference model, updated on each rising edge
  bit m_busy, m_done, m_en;
  int m_idx, m_cnt, m_req, m_pcr;
  int m_cfg[4];
  int m_pcn[4];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_en = 0; m_idx = 0; m_cnt = 4;
      m_req = 0; m_pcr = 0;
      for (int i = 0; i < 4; i++) begin m_cfg[i] = 0; m_pcn[i] = 0; end
    end else if (!m_busy) begin
      if (start) begin
        m_req = adj_req; m_pcr = pc2_req; m_en = pc2_en;
        m_cnt = (lane_cnt == 0) ? 1 : ((lane_cnt > 4) ? 4 : int'(lane_cnt));
        for (int i = 0; i < 4; i++) begin m_cfg[i] = 0; m_pcn[i] = 0; end
        m_busy = 1; m_done = 0; m_idx = 0;
      end
    end else if (drv_ready) begin
      m_cfg[m_idx] = exp_cfg((m_req >> (4 * m_idx)) & 15);
      m_pcn[m_idx] = m_en ? exp_pcn((m_pcr >> (2 * m_idx)) & 3) : 0;
      if (m_idx == m_cnt - 1) begin m_busy = 0; m_done = 1; end
      else m_idx++;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      int e, p, ecfg, epc;
      chk(busy == m_busy, "R8 busy", busy, m_busy);
      chk(done == m_done, "R8 done", done, m_done);
      chk(drv_valid == m_busy, "R7 drv_valid", drv_valid, m_busy);
      if (m_busy) begin
        e = exp_cfg((m_req >> (4 * m_idx)) & 15);
        p = m_en ? exp_pcn((m_pcr >> (2 * m_idx)) & 3) : 0;
        chk(drv_lane == m_idx, "R7 drv_lane", drv_lane, m_idx);
        chk(drv_swing == e % 4, "R3 drv_swing", drv_swing, e % 4);
        chk(drv_pre == (e / 8) % 4, "R3 drv_pre", drv_pre, (e / 8) % 4);
        chk(drv_pc2 == p % 4, "R6 drv_pc2", drv_pc2, p % 4);
      end
      ecfg = 0; epc = 0;
      for (int i = 0; i < 4; i++) begin
        ecfg = ecfg | (m_cfg[i] << (8 * i));
        epc  = epc  | (m_pcn[i] << (4 * i));
      end
      chk(lane_cfg == ecfg, "R10 lane_cfg", lane_cfg, ecfg);
      chk(pc2_cfg == epc[15:0], "R6 pc2_cfg", pc2_cfg, epc);
    end
  end

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      fails++;
      $display("FAIL R8 watchdog act=%0d exp<20000", wd);
      summary();
      $finish;
    end
  end

  task automatic start_pass(input logic [15:0] r, input logic [7:0] p,
                            input logic en, input logic [2:0] c);
    @(negedge clk);
    adj_req = r; pc2_req = p; pc2_en = en; lane_cnt = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // mode 0: ready always high; mode 1: ready toggles each cycle
  task automatic run(input int mode);
    int k;
    k = 0;
    while (!done && k < 100) begin
      @(negedge clk);
      if (mode == 0) drv_ready = 1'b1;
      else drv_ready = ~drv_ready;
      k++;
    end
    drv_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state under reset
    chk(busy == 0 && done == 0 && drv_valid == 0, "R1 flags",
        {busy, done, drv_valid}, 0);
    chk(lane_cfg == 0 && pc2_cfg == 0, "R1 results", lane_cfg, 0);
    rst_n = 1'b1;

    // Four lanes, every limit case, ready always high
    start_pass(16'hC653, 8'hE4, 1'b1, 3'd4);
    run(0);
    chk(lane_cfg[15:8] == 8'h09, "R3 lane1 pass-through", lane_cfg[15:8], 8'h09);
    chk(lane_cfg[31:24] == 8'h38, "R4 lane3 pre limit", lane_cfg[31:24], 8'h38);
    chk(lane_cfg[7:0] == 8'h07, "R5 lane0 swing limit", lane_cfg[7:0], 8'h07);
    chk(lane_cfg[23:16] == 8'h0E, "R5 lane2 swing limit", lane_cfg[23:16], 8'h0E);
    chk(pc2_cfg == 16'h7210, "R6 pc2 packing", pc2_cfg, 16'h7210);
    chk(done == 1 && busy == 0, "R8 done after pass", {done, busy}, 2'b10);

    // Two lanes, post-cursor2 disabled, back-pressure
    start_pass(16'hFFA0, 8'hFF, 1'b0, 3'd2);
    run(1);
    chk(lane_cfg == 32'h0000_1500, "R11 two lanes only", lane_cfg, 32'h0000_1500);
    chk(pc2_cfg == 16'h0000, "R6 pc2 disabled", pc2_cfg, 16'h0000);

    // One lane; start pulsed while busy and stalled
    start_pass(16'h0001, 8'h03, 1'b1, 3'd1);
    @(negedge clk);
    adj_req = 16'h3333; pc2_req = 8'h00; lane_cnt = 3'd4; start = 1'b1;
    repeat (3) @(negedge clk);
    chk(drv_valid == 1 && drv_lane == 0, "R7 stall holds beat",
        {drv_valid, drv_lane}, 3'b100);
    start = 1'b0;
    run(0);
    chk(lane_cfg == 32'h0000_0001, "R9 start while busy ignored",
        lane_cfg, 32'h0000_0001);
    chk(pc2_cfg == 16'h0007, "R10 stale nibbles cleared", pc2_cfg, 16'h0007);
    repeat (3) @(negedge clk);
    chk(done == 1, "R8 done held", done, 1);

    // Count of zero behaves as one
    start_pass(16'h000A, 8'h00, 1'b1, 3'd0);
    run(0);
    chk(lane_cfg == 32'h0000_0015, "R11 zero count", lane_cfg, 32'h0000_0015);

    // Three lanes, nibble placement across the byte boundary
    start_pass(16'h0F59, 8'h16, 1'b1, 3'd3);
    run(1);
    chk(lane_cfg == 32'h0038_0915, "R2 nibble placement", lane_cfg, 32'h0038_0915);
    chk(pc2_cfg == 16'h0112, "R2 pc2 field placement", pc2_cfg, 16'h0112);

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule